// File: doc/BRIEF.md
# Cache Parameter Search Tuner

The tuner sits next to a configurable cache and picks a low-energy setting for it without trying every combination. It drives a configuration word to the cache, waits for the cache to run a measurement window under that setting, and then reads the window's hit, miss and cycle counts together with the per-access and per-cycle energy constants for the setting under test. One multiplier and one adder, time-shared over three cycles, turn those values into an energy figure. A comparator checks that figure against the lowest energy seen so far.

The search is greedy and handles one parameter at a time: cache size, then line size, then associativity, then way prediction. Inside a parameter, the candidate values are tried in rising order. The search of that parameter ends at the first candidate that does not beat the stored minimum, or when its values run out. The winning value is then frozen and the next parameter is explored around it. The number of evaluations therefore grows with the sum of the option counts and not with their product. After the last parameter, the best configuration is applied, a done flag is raised and the tuner goes idle until it is started again.

Top module: `cache_tune_search`

## Requirements
- R1: After reset, `cfg_o` is all zeros and `done_o` is low.
- R2: The energy of a window is hits×`e_hit_i` + misses×`e_miss_i` + cycles×`e_static_i`. The counter and constant inputs are read during the three cycles that follow the strobe cycle and must be held over that span.
- R3: `cfg_o` holds the size index in bits [1:0], the line-size index in bits [3:2], the associativity index in bits [5:4] and way prediction enable in bit 6. A `start_i` pulse, accepted only while idle or done, sets `cfg_o` to all zeros and starts a search.
- R4: A `window_done_i` pulse sampled while the tuner waits for a measurement produces the next `cfg_o` exactly four clock edges after the edge that sampled it. Before then, `cfg_o` does not change.
- R5: Parameters are explored in the fixed order size, line size, associativity, way prediction. The option counts are N_SIZE, N_LINE, N_ASSOC and 2.
- R6: A candidate becomes the new best only if its energy is strictly lower than the stored minimum. A tie or a higher energy ends the search of that parameter.
- R7: Inside a parameter, candidates are tried in rising order starting from index 1. Every other field stays at its best value so far, and a losing candidate's field returns to the best value.
- R8: After the last parameter is resolved, `cfg_o` shows the best configuration and `done_o` is high. Both hold, and further `window_done_i` pulses have no effect, until `start_i`.
- R9: The first evaluation of a search, the all-zeros configuration, sets the minimum whatever its energy.
- R10: A `window_done_i` pulse that arrives while an energy computation is in progress is ignored.
- R11: A `start_i` pulse while done discards the previous result and runs a fresh search from the all-zeros configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new search |
| window_done_i | input | 1 | Measurement window under `cfg_o` has ended |
| hits_i | input | CW | Hit count of the window |
| misses_i | input | CW | Miss count of the window |
| cycles_i | input | CW | Cycle count of the window |
| e_hit_i | input | EW | Energy per hit for the configuration under test |
| e_miss_i | input | EW | Energy per miss for the configuration under test |
| e_static_i | input | EW | Static energy per cycle for the configuration under test |
| cfg_o | output | 7 | Configuration word driven to the cache |
| done_o | output | 1 | Search finished, best configuration applied |

## Verification
A corrupted energy sum, a wrong minimum or a wrong candidate counter shows up as a wrong `cfg_o` four edges after the strobe that ended the faulty evaluation. The reason is that every decision of the search is visible in the next trial configuration. A bad phase or stop decision either changes the length of the trial sequence or raises `done_o` too early or too late. Every trial word is compared against a sequence that the bench recomputes from the energy formula, so a fault is caught at the first evaluation where it alters the search path.

// File: rtl/cache_tune_search.sv
module cache_tune_search #(
  parameter int CW = 16,
  parameter int EW = 12,
  parameter int N_SIZE = 3,
  parameter int N_LINE = 3,
  parameter int N_ASSOC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          window_done_i,
  input  logic [CW-1:0] hits_i,
  input  logic [CW-1:0] misses_i,
  input  logic [CW-1:0] cycles_i,
  input  logic [EW-1:0] e_hit_i,
  input  logic [EW-1:0] e_miss_i,
  input  logic [EW-1:0] e_static_i,
  output logic [6:0]    cfg_o,
  output logic          done_o
);
  localparam int FW = 2;
  localparam int CFGW = 3*FW + 1;
  localparam int AW = CW + EW + 2;
  localparam logic [2:0] NS = 3'(N_SIZE);
  localparam logic [2:0] NL = 3'(N_LINE);
  localparam logic [2:0] NA = 3'(N_ASSOC);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_ACC, S_CMP, S_DONE} st_t;

  st_t            st;
  logic [CFGW-1:0] cur, best;
  logic [AW-1:0]   acc, min_e;
  logic [1:0]      ph, k;
  logic [FW-1:0]   cand;
  logic            first;

  function automatic logic [CFGW-1:0] put(input logic [CFGW-1:0] c, input logic [1:0] p,
                                          input logic [FW-1:0] v);
    logic [CFGW-1:0] r;
    r = c;
    case (p)
      2'd0: r[FW-1:0] = v;
      2'd1: r[2*FW-1:FW] = v;
      2'd2: r[3*FW-1:2*FW] = v;
      default: r[CFGW-1] = v[0];
    endcase
    return r;
  endfunction

  function automatic logic [2:0] nopt(input logic [1:0] p);
    case (p)
      2'd0: return NS;
      2'd1: return NL;
      2'd2: return NA;
      default: return 3'd2;
    endcase
  endfunction

  logic [CW-1:0]    opa;
  logic [EW-1:0]    opb;
  logic [CW+EW-1:0] prod;
  assign opa  = (k == 2'd0) ? hits_i : (k == 2'd1) ? misses_i : cycles_i;
  assign opb  = (k == 2'd0) ? e_hit_i : (k == 2'd1) ? e_miss_i : e_static_i;
  assign prod = opa * opb;

  logic            better, last_in_ph;
  logic [CFGW-1:0] best_nx;
  assign better     = first || (acc < min_e);
  assign best_nx    = better ? cur : best;
  assign last_in_ph = !better || (({1'b0, cand} + 3'd1) >= nopt(ph));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur <= '0;
      best <= '0;
      acc <= '0;
      min_e <= '0;
      ph <= '0;
      k <= '0;
      cand <= '0;
      first <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start_i) begin
          st <= S_WAIT;
          cur <= '0;
          best <= '0;
          ph <= '0;
          cand <= '0;
          first <= 1'b1;
        end
        S_WAIT: if (window_done_i) begin
          st <= S_ACC;
          acc <= '0;
          k <= '0;
        end
        S_ACC: begin
          acc <= acc + AW'(prod);
          k <= k + 2'd1;
          if (k == 2'd2) st <= S_CMP;
        end
        default: begin
          first <= 1'b0;
          if (better) min_e <= acc;
          best <= best_nx;
          if (!last_in_ph) begin
            cand <= cand + 1'b1;
            cur <= put(best_nx, ph, cand + 1'b1);
            st <= S_WAIT;
          end else if (ph == 2'd3) begin
            cur <= best_nx;
            st <= S_DONE;
          end else begin
            ph <= ph + 2'd1;
            cand <= FW'(1);
            cur <= put(best_nx, ph + 2'd1, FW'(1));
            st <= S_WAIT;
          end
        end
      endcase
    end
  end

  assign cfg_o  = cur;
  assign done_o = (st == S_DONE);

  p_wait_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) && $past(st == S_WAIT) |-> $stable(cur));

  p_acc_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMP) |-> $past(st == S_ACC) && $past(st == S_ACC, 3));

  p_min_nonincr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMP) && !first |=> min_e <= $past(min_e));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE) && !start_i |=> (st == S_DONE) && $stable(cur));

  p_phase_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(st inside {S_IDLE, S_DONE}) |=> ph >= $past(ph));

  p_field_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> ({1'b0, cur[1:0]} < NS) && ({1'b0, cur[3:2]} < NL) && ({1'b0, cur[5:4]} < NA));
endmodule

// File: tb/cache_tune_search_tb.sv
module cache_tune_search_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NOPT[4] = '{3, 3, 3, 2};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        window_done_i = 1'b0;
  logic [15:0] hits_i = '0, misses_i = '0, cycles_i = '0;
  logic [11:0] e_hit_i = '0, e_miss_i = '0, e_static_i = '0;
  logic [6:0]  cfg_o;
  logic        done_o;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_tune_search dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .window_done_i(window_done_i),
    .hits_i(hits_i), .misses_i(misses_i), .cycles_i(cycles_i),
    .e_hit_i(e_hit_i), .e_miss_i(e_miss_i), .e_static_i(e_static_i),
    .cfg_o(cfg_o), .done_o(done_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void vals(input int kind, input int c, output int h, output int m,
                               output int cy, output int eh, output int em, output int es);
    int s, l, a, w;
    s = c & 3; l = (c >> 2) & 3; a = (c >> 4) & 3; w = (c >> 6) & 1;
    if (kind == 0) begin
      h = 1000; m = 100; cy = 5000; eh = 4; em = 40; es = 1;
    end else if (kind == 1) begin
      h = 2000; m = 800 - 100*(s+l+a+w); cy = 9000 - 500*(s+l+a+w); eh = 3; em = 50; es = 2;
    end else begin
      h  = 1000 + ((s*7 + l*13 + a*5 + w*3 + kind*11) % 17) * 60;
      m  = 50 + ((s*3 + l*11 + a*7 + w*5 + kind*5) % 13) * 20;
      cy = 4000 + ((s*5 + l*3 + a*11 + w*7 + kind*3) % 11) * 150;
      eh = 2 + (s + a + kind) % 3;
      em = 30 + l*4 + kind % 5;
      es = 1 + (w + s + kind) % 3;
    end
  endfunction

  function automatic int energy(input int kind, input int c);
    int h, m, cy, eh, em, es;
    vals(kind, c, h, m, cy, eh, em, es);
    return h*eh + m*em + cy*es;
  endfunction

  task automatic run_search(input int kind);
    int exp_cfg[16];
    int n, best, best_e;
    n = 0; best = 0; best_e = energy(kind, 0);
    exp_cfg[n++] = 0;
    for (int p = 0; p < 4; p++) begin
      for (int v = 1; v < NOPT[p]; v++) begin
        int t, e;
        t = (best & ~(3 << (2*p))) | (v << (2*p));
        exp_cfg[n++] = t;
        e = energy(kind, t);
        if (e < best_e) begin best_e = e; best = t; end
        else break;
      end
    end

    @(negedge clk) start_i = 1'b1;
    @(posedge clk); @(negedge clk) start_i = 1'b0;
    chk(cfg_o == 7'd0, "R3/R11 start config", cfg_o, 0);
    for (int i = 0; i < n; i++) begin
      int h, m, cy, eh, em, es;
      chk(cfg_o == 7'(exp_cfg[i]), (i == 1) ? "R9/R5/R7 trial config" : "R5/R6/R7 trial config",
          cfg_o, exp_cfg[i]);
      chk(done_o == 1'b0, "R8 done low while searching", done_o, 0);
      vals(kind, exp_cfg[i], h, m, cy, eh, em, es);
      hits_i = 16'(h); misses_i = 16'(m); cycles_i = 16'(cy);
      e_hit_i = 12'(eh); e_miss_i = 12'(em); e_static_i = 12'(es);
      window_done_i = 1'b1;
      @(posedge clk); @(negedge clk) window_done_i = 1'b0;
      @(posedge clk); @(negedge clk) if (i == 0) window_done_i = 1'b1;
      @(posedge clk); @(negedge clk) window_done_i = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(cfg_o == 7'(exp_cfg[i]), "R4 config held during compute (R10 strobe ignored)",
          cfg_o, exp_cfg[i]);
      @(posedge clk); @(negedge clk);
    end
    chk(cfg_o == 7'(best), "R2/R6 best config applied", cfg_o, best);
    chk(done_o == 1'b1, "R8 done raised", done_o, 1);
    window_done_i = 1'b1;
    @(posedge clk); @(negedge clk) window_done_i = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(cfg_o == 7'(best) && done_o, "R8 strobe ignored when done", cfg_o, best);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cfg_o == 7'd0, "R1 reset cfg", cfg_o, 0);
    chk(done_o == 1'b0, "R1 reset done", done_o, 0);
    rst_n = 1'b1;
    @(negedge clk) window_done_i = 1'b1;
    @(posedge clk); @(negedge clk) window_done_i = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(cfg_o == 7'd0 && !done_o, "R1 idle ignores strobe", cfg_o, 0);
    for (int kind = 0; kind < 12; kind++) run_search(kind);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule